// File: doc/BRIEF.md
# Product-Term Sum Cell with Polarity Control

This block is the combinational datapath of one programmable logic cell. It takes five product terms from an AND array that lives outside it. It divides them between an OR sum and a second XOR operand, and it can widen the sum with a cascade bit from the neighbouring cell. It applies a polarity or XOR step to form the data that feeds the cell's register. It then picks the pin data, the buried feedback and the pin enable.

The pin data and the feedback each choose, on their own, between the combinational result and the registered value `reg_q_i` returned by the external register. The pin enable is always on, always off (so the pin can serve as an input), one of two dedicated enable inputs, or one of the product terms. The cell also drives the inverse of one chosen product term as a foldback term. Chaining `cas_o` into the next cell's `cas_i` builds sums of up to 40 terms across eight cells.

Top module: `pterm_cell`

## Requirements
- R1: `cas_o` is the OR of every product term `pt_i[i]` whose bit `or_mask_i[i]` is 1, apart from any term removed under R4, together with the cascade contribution of R2.
- R2: With `cas_en_i` = 1, `cas_i` is ORed into the sum. With `cas_en_i` = 0, `cas_i` has no effect. In a chain of eight cells, where each `cas_o` feeds the next cell's `cas_i` and the enable is set, a single true term in any cell reaches the last `cas_o`, so 40 terms form one sum.
- R3: `d_o` is `cas_o` XOR an operand chosen by `xor_mode_i`: 0 gives constant 0, 1 gives constant 1 (output inverted), 2 gives `pt_i[xor_idx_i]`, and 3 behaves as 0.
- R4: In mode 2, the term at `xor_idx_i` is left out of the OR sum even when its mask bit is set. An index of 5 or more gives operand 0 and removes no term.
- R5: `pin_o` equals `reg_q_i` when `out_reg_i` = 1 and equals `d_o` when it is 0.
- R6: `fb_o` equals `reg_q_i` when `fb_reg_i` = 1 and equals `d_o` when it is 0, whatever the value of `out_reg_i`.
- R7: `pin_oe_o` follows `oe_mode_i`: 0 gives 0, 1 gives 1, 2 gives `oe_ded_i[oe_idx_i]` (0 for an index of 2 or more), and 3 gives `pt_i[oe_idx_i]` (0 for an index of 5 or more).
- R8: `fold_o` is the inverse of `pt_i[fold_idx_i]`. An index of 5 or more gives 1.
- R9: `pin_o` carries the selected data whatever the value of `pin_oe_o`. High impedance is expressed only through the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pt_i | input | 5 | Product terms from the AND array |
| cas_i | input | 1 | Cascade sum from the previous cell |
| oe_ded_i | input | 2 | Dedicated output-enable inputs |
| reg_q_i | input | 1 | Output of the external cell register |
| or_mask_i | input | 5 | Allocation of terms to the OR sum |
| cas_en_i | input | 1 | Accept the cascade input |
| xor_mode_i | input | 2 | Second XOR operand select |
| xor_idx_i | input | 3 | Term used as the XOR operand |
| out_reg_i | input | 1 | Pin data from the register |
| fb_reg_i | input | 1 | Feedback from the register |
| oe_mode_i | input | 2 | Output-enable source select |
| oe_idx_i | input | 3 | Index of the enable input or term |
| fold_idx_i | input | 3 | Term that is inverted for foldback |
| cas_o | output | 1 | OR sum including the cascade, to the next cell |
| d_o | output | 1 | XOR result, the data input of the register |
| pin_o | output | 1 | Pin data |
| pin_oe_o | output | 1 | Pin enable (0 means high impedance) |
| fb_o | output | 1 | Buried feedback |
| fold_o | output | 1 | Foldback term |

## Verification
The bench builds the cell with its default five terms and two dedicated enables, which makes index values 5 to 7 and 2 to 7 reachable as out-of-range cases for every selector. A second group of eight default cells is chained through the cascade, so that a 40-term sum is exercised end to end. A vector table covers the allocation, polarity and routing cases. A seeded sweep then compares all outputs against a model built from the requirements.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  typedef enum logic [1:0] {
    XOP_ZERO = 2'd0,
    XOP_ONE  = 2'd1,
    XOP_TERM = 2'd2,
    XOP_RSVD = 2'd3
  } xop_e;

  typedef enum logic [1:0] {
    OEN_OFF  = 2'd0,
    OEN_ON   = 2'd1,
    OEN_DED  = 2'd2,
    OEN_TERM = 2'd3
  } oen_e;
endpackage

// File: rtl/ptc_sum.sv
module ptc_sum
  import ptc_pkg::*;
#(
  parameter int N_PT  = 5,
  parameter int IDX_W = 3
) (
  input  logic [N_PT-1:0]  pt_i,
  input  logic [N_PT-1:0]  mask_i,
  input  xop_e             xor_mode_i,
  input  logic [IDX_W-1:0] xor_idx_i,
  input  logic             cas_i,
  input  logic             cas_en_i,
  output logic             sum_o
);
  logic [N_PT-1:0] strip;
  logic [N_PT-1:0] alloc;

  // the term claimed by the XOR operand leaves the OR sum
  for (genvar g = 0; g < N_PT; g++) begin : g_strip
    assign strip[g] = (xor_mode_i == XOP_TERM) && (xor_idx_i == IDX_W'(g));
  end

  assign alloc = mask_i & ~strip;
  assign sum_o = (|(pt_i & alloc)) | (cas_en_i & cas_i);

  always_comb begin
    if (xor_mode_i == XOP_TERM && !cas_en_i && (pt_i & ~strip) == '0)
      p_removed_term_r4: assert (!sum_o)
        else $error("R4: claimed term leaked into sum");
    if (!cas_en_i && (pt_i & mask_i) == '0)
      p_cascade_gated_r2: assert (!sum_o)
        else $error("R2: cascade passed while disabled");
  end
endmodule

// File: rtl/ptc_polarity.sv
module ptc_polarity
  import ptc_pkg::*;
#(
  parameter int N_PT  = 5,
  parameter int IDX_W = 3
) (
  input  logic             sum_i,
  input  logic [N_PT-1:0]  pt_i,
  input  xop_e             xor_mode_i,
  input  logic [IDX_W-1:0] xor_idx_i,
  output logic             d_o
);
  logic term_sel;
  logic op;

  always_comb begin
    term_sel = 1'b0;
    for (int i = 0; i < N_PT; i++)
      if (xor_idx_i == IDX_W'(i)) term_sel = pt_i[i];
  end

  always_comb begin
    unique case (xor_mode_i)
      XOP_ONE:  op = 1'b1;
      XOP_TERM: op = term_sel;
      default:  op = 1'b0;
    endcase
  end

  assign d_o = sum_i ^ op;
endmodule

// File: rtl/ptc_route.sv
module ptc_route
  import ptc_pkg::*;
#(
  parameter int N_PT  = 5,
  parameter int N_OE  = 2,
  parameter int IDX_W = 3
) (
  input  logic             d_i,
  input  logic             reg_q_i,
  input  logic             out_reg_i,
  input  logic             fb_reg_i,
  input  oen_e             oe_mode_i,
  input  logic [IDX_W-1:0] oe_idx_i,
  input  logic [N_OE-1:0]  oe_ded_i,
  input  logic [N_PT-1:0]  pt_i,
  input  logic [IDX_W-1:0] fold_idx_i,
  output logic             pin_o,
  output logic             pin_oe_o,
  output logic             fb_o,
  output logic             fold_o
);
  logic ded_sel, term_sel, fold_term;

  assign pin_o = out_reg_i ? reg_q_i : d_i;
  assign fb_o  = fb_reg_i  ? reg_q_i : d_i;

  always_comb begin
    ded_sel   = 1'b0;
    term_sel  = 1'b0;
    fold_term = 1'b0;
    for (int i = 0; i < N_OE; i++)
      if (oe_idx_i == IDX_W'(i)) ded_sel = oe_ded_i[i];
    for (int i = 0; i < N_PT; i++) begin
      if (oe_idx_i == IDX_W'(i))   term_sel  = pt_i[i];
      if (fold_idx_i == IDX_W'(i)) fold_term = pt_i[i];
    end
  end

  always_comb begin
    unique case (oe_mode_i)
      OEN_ON:   pin_oe_o = 1'b1;
      OEN_DED:  pin_oe_o = ded_sel;
      OEN_TERM: pin_oe_o = term_sel;
      default:  pin_oe_o = 1'b0;
    endcase
  end

  assign fold_o = ~fold_term;

  always_comb begin
    if (oe_mode_i == OEN_OFF)
      p_oe_off_r7: assert (!pin_oe_o) else $error("R7: enable on in off mode");
    if (oe_mode_i == OEN_ON)
      p_oe_on_r7: assert (pin_oe_o) else $error("R7: enable off in on mode");
  end
endmodule

// File: rtl/pterm_cell.sv
module pterm_cell
  import ptc_pkg::*;
#(
  parameter int N_PT  = 5,
  parameter int N_OE  = 2,
  localparam int IDX_W = (N_PT > N_OE) ? $clog2(N_PT + 1) : $clog2(N_OE + 1)
) (
  input  logic [N_PT-1:0]  pt_i,
  input  logic             cas_i,
  input  logic [N_OE-1:0]  oe_ded_i,
  input  logic             reg_q_i,
  input  logic [N_PT-1:0]  or_mask_i,
  input  logic             cas_en_i,
  input  logic [1:0]       xor_mode_i,
  input  logic [IDX_W-1:0] xor_idx_i,
  input  logic             out_reg_i,
  input  logic             fb_reg_i,
  input  logic [1:0]       oe_mode_i,
  input  logic [IDX_W-1:0] oe_idx_i,
  input  logic [IDX_W-1:0] fold_idx_i,
  output logic             cas_o,
  output logic             d_o,
  output logic             pin_o,
  output logic             pin_oe_o,
  output logic             fb_o,
  output logic             fold_o
);
  xop_e xmode;
  oen_e omode;
  logic sum;

  assign xmode = xop_e'(xor_mode_i);
  assign omode = oen_e'(oe_mode_i);

  ptc_sum #(.N_PT(N_PT), .IDX_W(IDX_W)) u_sum (
    .pt_i       (pt_i),
    .mask_i     (or_mask_i),
    .xor_mode_i (xmode),
    .xor_idx_i  (xor_idx_i),
    .cas_i      (cas_i),
    .cas_en_i   (cas_en_i),
    .sum_o      (sum)
  );

  ptc_polarity #(.N_PT(N_PT), .IDX_W(IDX_W)) u_pol (
    .sum_i      (sum),
    .pt_i       (pt_i),
    .xor_mode_i (xmode),
    .xor_idx_i  (xor_idx_i),
    .d_o        (d_o)
  );

  ptc_route #(.N_PT(N_PT), .N_OE(N_OE), .IDX_W(IDX_W)) u_route (
    .d_i        (d_o),
    .reg_q_i    (reg_q_i),
    .out_reg_i  (out_reg_i),
    .fb_reg_i   (fb_reg_i),
    .oe_mode_i  (omode),
    .oe_idx_i   (oe_idx_i),
    .oe_ded_i   (oe_ded_i),
    .pt_i       (pt_i),
    .fold_idx_i (fold_idx_i),
    .pin_o      (pin_o),
    .pin_oe_o   (pin_oe_o),
    .fb_o       (fb_o),
    .fold_o     (fold_o)
  );

  assign cas_o = sum;

  always_comb begin
    if (xmode == XOP_ZERO || xmode == XOP_RSVD)
      p_const0_r3: assert (d_o == cas_o) else $error("R3: zero operand altered data");
    if (xmode == XOP_ONE)
      p_const1_r3: assert (d_o != cas_o) else $error("R3: one operand did not invert");
    if (|(pt_i & or_mask_i) && xmode != XOP_TERM)
      p_term_sets_sum_r1: assert (cas_o) else $error("R1: allocated term lost");
    if (!out_reg_i)
      p_pin_comb_r5: assert (pin_o == d_o) else $error("R5: pin not combinational");
    if (!fb_reg_i)
      p_fb_comb_r6: assert (fb_o == d_o) else $error("R6: feedback not combinational");
    if (fb_reg_i)
      p_fb_reg_r6: assert (fb_o == reg_q_i) else $error("R6: feedback not registered");
  end
endmodule

// File: tb/pterm_cell_bench.sv
module pterm_cell_bench;
  localparam int N_PT  = 5;
  localparam int N_OE  = 2;
  localparam int IDX_W = 3;
  localparam int N_CH  = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [4:0] pt, mask;
  logic       cas, q, cen, oreg, freg;
  logic [1:0] ded, xm, om;
  logic [2:0] xi, oi, fi;
  logic       cas_o, d_o, pin_o, oe_o, fb_o, fold_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  pterm_cell u_pterm_cell (
    .pt_i(pt), .cas_i(cas), .oe_ded_i(ded), .reg_q_i(q), .or_mask_i(mask),
    .cas_en_i(cen), .xor_mode_i(xm), .xor_idx_i(xi), .out_reg_i(oreg),
    .fb_reg_i(freg), .oe_mode_i(om), .oe_idx_i(oi), .fold_idx_i(fi),
    .cas_o(cas_o), .d_o(d_o), .pin_o(pin_o), .pin_oe_o(oe_o), .fb_o(fb_o),
    .fold_o(fold_o)
  );

  // eight chained cells for a 40-term sum
  logic [4:0] ch_pt [N_CH];
  logic [N_CH:0] ch_cas;
  logic [N_CH-1:0] ch_d, ch_pin, ch_oe, ch_fb, ch_fold;
  assign ch_cas[0] = 1'b0;
  for (genvar k = 0; k < N_CH; k++) begin : g_chain
    pterm_cell u_chain (
      .pt_i(ch_pt[k]), .cas_i(ch_cas[k]), .oe_ded_i(2'b00), .reg_q_i(1'b0),
      .or_mask_i(5'b11111), .cas_en_i(k != 0), .xor_mode_i(2'd0),
      .xor_idx_i(3'd0), .out_reg_i(1'b0), .fb_reg_i(1'b0), .oe_mode_i(2'd1),
      .oe_idx_i(3'd0), .fold_idx_i(3'd0), .cas_o(ch_cas[k+1]), .d_o(ch_d[k]),
      .pin_o(ch_pin[k]), .pin_oe_o(ch_oe[k]), .fb_o(ch_fb[k]), .fold_o(ch_fold[k])
    );
  end

  typedef struct packed {
    logic [4:0] pt;   logic cas; logic [1:0] ded; logic q;
    logic [4:0] mask; logic cen; logic [1:0] xm;  logic [2:0] xi;
    logic oreg; logic freg; logic [1:0] om; logic [2:0] oi; logic [2:0] fi;
    logic [5:0] exp;  // {cas_o, d_o, pin_o, pin_oe_o, fb_o, fold_o}
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{5'b00000,1'b0,2'b00,1'b0,5'b11111,1'b0,2'd0,3'd0,1'b0,1'b0,2'd1,3'd0,3'd0,6'b000101},
    '{5'b00100,1'b0,2'b00,1'b0,5'b11111,1'b0,2'd0,3'd0,1'b0,1'b0,2'd1,3'd0,3'd2,6'b111110},
    '{5'b00100,1'b0,2'b00,1'b0,5'b11011,1'b0,2'd0,3'd0,1'b0,1'b0,2'd0,3'd0,3'd0,6'b000001},
    '{5'b00001,1'b0,2'b10,1'b0,5'b11111,1'b0,2'd1,3'd0,1'b0,1'b0,2'd2,3'd1,3'd1,6'b100101},
    '{5'b10001,1'b0,2'b00,1'b0,5'b11111,1'b0,2'd2,3'd4,1'b0,1'b0,2'd3,3'd4,3'd4,6'b100100},
    '{5'b01000,1'b1,2'b00,1'b0,5'b11111,1'b0,2'd2,3'd3,1'b0,1'b0,2'd3,3'd0,3'd3,6'b011010},
    '{5'b00000,1'b1,2'b10,1'b0,5'b11111,1'b1,2'd0,3'd0,1'b1,1'b0,2'd2,3'd0,3'd0,6'b110011},
    '{5'b00010,1'b0,2'b01,1'b1,5'b00010,1'b0,2'd1,3'd0,1'b0,1'b1,2'd2,3'd0,3'd1,6'b100110}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [5:0] model();
    logic [4:0] m;
    logic s, op, d, oe, fo;
    m = mask;
    if (xm == 2'd2 && xi < 3'd5) m[xi] = 1'b0;
    s = (|(pt & m)) | (cen & cas);
    op = (xm == 2'd1) ? 1'b1 : (xm == 2'd2 && xi < 3'd5) ? pt[xi] : 1'b0;
    d = s ^ op;
    case (om)
      2'd0: oe = 1'b0;
      2'd1: oe = 1'b1;
      2'd2: oe = (oi < 3'd2) ? ded[oi[0]] : 1'b0;
      default: oe = (oi < 3'd5) ? pt[oi] : 1'b0;
    endcase
    fo = (fi < 3'd5) ? ~pt[fi] : 1'b1;
    return {s, d, oreg ? q : d, oe, freg ? q : d, fo};
  endfunction

  task automatic check_all(input string tag, input logic [5:0] e);
    chk({tag, " R1 cas_o"},    cas_o,  e[5]);
    chk({tag, " R3 d_o"},      d_o,    e[4]);
    chk({tag, " R5 pin_o"},    pin_o,  e[3]);
    chk({tag, " R7 pin_oe_o"}, oe_o,   e[2]);
    chk({tag, " R6 fb_o"},     fb_o,   e[1]);
    chk({tag, " R8 fold_o"},   fold_o, e[0]);
  endtask

  task automatic settle();
    @(negedge clk);
    #2;
  endtask

  task automatic idle();
    pt = '0; cas = 0; ded = '0; q = 0; mask = '0; cen = 0; xm = '0; xi = '0;
    oreg = 0; freg = 0; om = '0; oi = '0; fi = '0;
  endtask

  initial begin
    idle();
    for (int k = 0; k < N_CH; k++) ch_pt[k] = '0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    settle();
    check_all("reset", 6'b000001);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      pt = VECS[v].pt; cas = VECS[v].cas; ded = VECS[v].ded; q = VECS[v].q;
      mask = VECS[v].mask; cen = VECS[v].cen; xm = VECS[v].xm; xi = VECS[v].xi;
      oreg = VECS[v].oreg; freg = VECS[v].freg; om = VECS[v].om;
      oi = VECS[v].oi; fi = VECS[v].fi;
      #2;
      check_all($sformatf("vec%0d", v), VECS[v].exp);
    end

    // R4: out-of-range operand index removes nothing, operand 0
    @(negedge clk); idle();
    pt = 5'b00001; mask = 5'b11111; xm = 2'd2; xi = 3'd6; #2;
    chk("R4 idx6 keeps sum", cas_o, 1'b1);
    chk("R4 idx6 operand zero", d_o, 1'b1);
    // R3: reserved mode acts as 0
    @(negedge clk); xm = 2'd3; #2;
    chk("R3 reserved mode", d_o, 1'b1);
    // R2: cascade ignored when disabled
    @(negedge clk); idle(); cas = 1; cen = 0; mask = 5'b11111; #2;
    chk("R2 cascade ignored", cas_o, 1'b0);
    // R7: out-of-range enable indices
    @(negedge clk); idle(); ded = 2'b11; om = 2'd2; oi = 3'd2; #2;
    chk("R7 ded idx2", oe_o, 1'b0);
    @(negedge clk); pt = 5'b11111; om = 2'd3; oi = 3'd5; #2;
    chk("R7 term idx5", oe_o, 1'b0);
    // R8: out-of-range foldback index
    @(negedge clk); fi = 3'd7; #2;
    chk("R8 fold idx7", fold_o, 1'b1);
    // R9: pin data present with enable off
    @(negedge clk); idle(); pt = 5'b00100; mask = 5'b00100; om = 2'd0; #2;
    chk("R9 pin data while disabled", pin_o, 1'b1);
    chk("R9 enable off", oe_o, 1'b0);

    // R2: 40-term chain, each term alone reaches the last cell
    for (int k = 0; k < N_CH; k++) begin
      for (int t = 0; t < N_PT; t++) begin
        @(negedge clk);
        for (int j = 0; j < N_CH; j++) ch_pt[j] = '0;
        ch_pt[k][t] = 1'b1;
        #2;
        chk($sformatf("R2 chain cell%0d term%0d", k, t), ch_cas[N_CH], 1'b1);
      end
    end
    @(negedge clk);
    for (int j = 0; j < N_CH; j++) ch_pt[j] = '0;
    #2;
    chk("R2 chain all clear", ch_cas[N_CH], 1'b0);

    // seeded sweep against the requirement model (R1..R9)
    void'($urandom(32'd17));
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r1, r2;
      @(negedge clk);
      r1 = $urandom(); r2 = $urandom();
      pt = r1[4:0]; cas = r1[5]; ded = r1[7:6]; q = r1[8]; mask = r1[13:9];
      cen = r1[14]; xm = r1[16:15]; xi = r1[19:17]; oreg = r1[20];
      freg = r1[21]; om = r1[23:22]; oi = r2[2:0]; fi = r2[5:3];
      #2;
      check_all($sformatf("sweep%0d", n), model());
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule